// File: doc/BRIEF.md
# Core-to-Network Packetizing Interface

This block joins a processing core to one port of an on-chip router. Toward the network, the core hands over a request: a destination core number, a payload of up to 56 bytes, and a byte count. The block translates the core number into a network node number. It pads the unused payload bytes with zeros and parks the message in a four-entry message queue. A serializer then cuts each queued message into eight 64-bit flits and writes them into an eight-flit output buffer. The router drains that buffer with a valid/ready handshake.

Toward the core, flits arriving from the router land in an eight-flit input buffer. An assembler rebuilds each message from its flits. It presents the message, together with the source node number taken from the head flit, once the tail flit is in. The message stays on offer until the core takes it.

Asynchronous reset is active low. Its release is synchronized inside the block, so outputs leave their reset values two clock edges after `rst_n` rises.

Top module: `nif_top`

## Requirements
- R1: After reset, `req_ready` and `in_ready` are 1, and `out_valid` and `rx_valid` are 0.
- R2: A flit is 64 bits wide. Bits [55:0] carry seven payload bytes: byte i of flit k (bits 8i+7:8i) is payload byte 7k+i, where payload byte j is `req_payload[8j+7:8j]`. Bits [63:56] form the header:
  - bit 63 marks the head flit and bit 62 the tail flit;
  - bits [61:56] hold the destination node in the head flit, and the flit index k in every other flit.
- R3: The destination node is (`req_core_id` + 5) modulo 64.
- R4: Each accepted message leaves as exactly eight flits in index order. Only flit 0 has the head bit and only flit 7 has the tail bit. While `out_valid` is 1 and `out_ready` is 0, `out_flit` holds its value.
- R5: Payload bytes with index at or above `req_nbytes` are sent as zero. A count above 56 sends all 56 bytes.
- R6: A request is taken only in a cycle where `req_valid` and `req_ready` are both 1. With the output stalled, exactly five messages are taken before `req_ready` falls: four in the queue plus one held as eight flits in the output buffer.
- R7: Messages leave in the order in which they were taken.
- R8: When the block is idle, the head flit of a message taken at clock edge E appears on `out_valid` after edge E+1.
- R9: A received message is offered on `rx_valid` only after its tail flit has been taken in. `rx_src` is the head flit's bits [61:56], and payload byte 7k+i comes from byte i of flit k.
- R10: `rx_valid`, `rx_src` and `rx_payload` hold until `rx_ready` is 1. While the core stalls, the block takes exactly 16 flits (one message in assembly plus eight buffered) before `in_ready` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Core request valid |
| req_ready | output | 1 | Message queue has space |
| req_core_id | input | 6 | Destination core number |
| req_nbytes | input | 6 | Count of meaningful payload bytes |
| req_payload | input | 448 | Message payload, byte j at bits 8j+7:8j |
| out_valid | output | 1 | Outgoing flit valid |
| out_ready | input | 1 | Router accepts the outgoing flit |
| out_flit | output | 64 | Outgoing flit |
| in_valid | input | 1 | Incoming flit valid |
| in_ready | output | 1 | Input buffer has space |
| in_flit | input | 64 | Incoming flit |
| rx_valid | output | 1 | Reassembled message valid |
| rx_ready | input | 1 | Core accepts the message |
| rx_src | output | 6 | Source node of the message |
| rx_payload | output | 448 | Reassembled payload |

## Verification
The assertions assume the router sends whole, well-formed messages on the input side: a head flit, six body flits, then a tail flit, with no head arriving in the middle of a message. The bench builds every incoming stream from complete eight-flit messages in that shape. It also drives the core side with only legal handshakes: payload and ID stay fixed from the cycle `req_valid` rises until the transfer, and every input changes on the falling clock edge.

// File: rtl/nif_pkg.sv
package nif_pkg;
  localparam int FLIT_W        = 64;
  localparam int DATA_BYTES    = 7;
  localparam int DATA_W        = DATA_BYTES * 8;
  localparam int FLITS_PER_MSG = 8;
  localparam int PAYLOAD_BYTES = DATA_BYTES * FLITS_PER_MSG;
  localparam int PAYLOAD_W     = PAYLOAD_BYTES * 8;
  localparam int NODE_W        = 6;
  localparam int IDX_W         = $clog2(FLITS_PER_MSG);
  localparam int HEAD_BIT      = 63;
  localparam int TAIL_BIT      = 62;
endpackage

// File: rtl/nif_fifo.sv
module nif_fifo #(
  parameter int W     = 64,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         empty,
  output logic         full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign empty = (cnt_q == '0);
  assign full  = (cnt_q == CNT_W'(DEPTH));
  assign rdata = mem[rd_q];

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (push) wr_d = (wr_q == PTR_W'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
    if (pop)  rd_d = (rd_q == PTR_W'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
    if (push && !pop) cnt_d = cnt_q + 1'b1;
    else if (pop && !push) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_q] <= wdata;
  end

  // R6: storage is never written past its depth
  a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (!full || pop));
  // R4: nothing is taken from an empty store
  a_r4_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
endmodule

// File: rtl/nif_tx_packer.sv
module nif_tx_packer
  import nif_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 msg_valid,
  input  logic [NODE_W-1:0]    msg_node,
  input  logic [PAYLOAD_W-1:0] msg_payload,
  output logic                 msg_pop,
  input  logic                 flit_full,
  output logic                 flit_push,
  output logic [FLIT_W-1:0]    flit_data
);
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             is_head, is_tail;

  assign is_head   = (idx_q == '0);
  assign is_tail   = (idx_q == IDX_W'(FLITS_PER_MSG - 1));
  assign flit_push = msg_valid && !flit_full;
  assign msg_pop   = flit_push && is_tail;

  always_comb begin
    flit_data[HEAD_BIT]  = is_head;
    flit_data[TAIL_BIT]  = is_tail;
    flit_data[61:56]     = is_head ? msg_node : NODE_W'(idx_q);
    flit_data[DATA_W-1:0] = msg_payload[int'(idx_q)*DATA_W +: DATA_W];
  end

  always_comb begin
    idx_d = idx_q;
    if (flit_push) idx_d = is_tail ? '0 : idx_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx_q <= '0;
    else        idx_q <= idx_d;
  end

  // R4: a message stays at the queue head, unchanged, until its tail flit leaves
  a_r4_msg_held: assert property (@(posedge clk) disable iff (!rst_n)
    (flit_push && !is_tail) |=> (msg_valid && $stable(msg_node)));
endmodule

// File: rtl/nif_rx_assembler.sv
module nif_rx_assembler
  import nif_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 flit_avail,
  input  logic [FLIT_W-1:0]    flit_data,
  output logic                 flit_pop,
  output logic                 rx_valid,
  input  logic                 rx_ready,
  output logic [NODE_W-1:0]    rx_src,
  output logic [PAYLOAD_W-1:0] rx_payload
);
  logic                 valid_q, valid_d;
  logic [IDX_W-1:0]     idx_q, idx_d;
  logic [NODE_W-1:0]    src_q, src_d;
  logic [PAYLOAD_W-1:0] pay_q, pay_d;
  logic                 f_head, f_tail;
  int                   slot;

  assign f_head   = flit_data[HEAD_BIT];
  assign f_tail   = flit_data[TAIL_BIT];
  assign flit_pop = flit_avail && !valid_q;
  assign slot     = f_head ? 0 : int'(idx_q);

  always_comb begin
    valid_d = valid_q;
    idx_d   = idx_q;
    src_d   = src_q;
    pay_d   = pay_q;
    if (valid_q && rx_ready) valid_d = 1'b0;
    if (flit_pop) begin
      pay_d[slot*DATA_W +: DATA_W] = flit_data[DATA_W-1:0];
      idx_d = IDX_W'(slot + 1);
      if (f_head) src_d = flit_data[61:56];
      if (f_tail) valid_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      idx_q   <= '0;
      src_q   <= '0;
    end else begin
      valid_q <= valid_d;
      idx_q   <= idx_d;
      src_q   <= src_d;
    end
  end

  always_ff @(posedge clk) begin
    if (flit_pop) pay_q <= pay_d;
  end

  assign rx_valid   = valid_q;
  assign rx_src     = src_q;
  assign rx_payload = pay_q;

  // R10: an offered message holds still until the core takes it
  a_r10_rx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_src) && $stable(rx_payload)));
  // R9: a message is offered only after a tail flit was taken in
  a_r9_tail_first: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_valid) |-> $past(flit_pop && f_tail));
endmodule

// File: rtl/nif_top.sv
module nif_top
  import nif_pkg::*;
#(
  parameter int MSGQ_DEPTH    = 4,
  parameter int FLITBUF_DEPTH = 8,
  parameter int NODE_BASE     = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [NODE_W-1:0]    req_core_id,
  input  logic [5:0]           req_nbytes,
  input  logic [PAYLOAD_W-1:0] req_payload,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [FLIT_W-1:0]    out_flit,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [FLIT_W-1:0]    in_flit,
  output logic                 rx_valid,
  input  logic                 rx_ready,
  output logic [NODE_W-1:0]    rx_src,
  output logic [PAYLOAD_W-1:0] rx_payload
);
  localparam int MSG_W = NODE_W + PAYLOAD_W;

  logic [1:0] rst_pipe;
  logic       rst_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s = rst_pipe[1];

  logic [NODE_W-1:0]    dest_node;
  logic [PAYLOAD_W-1:0] padded;

  assign dest_node = NODE_W'(int'(req_core_id) + NODE_BASE);

  always_comb begin
    for (int j = 0; j < PAYLOAD_BYTES; j++) begin
      padded[8*j +: 8] = (j < int'(req_nbytes)) ? req_payload[8*j +: 8] : 8'h00;
    end
  end

  logic             mq_push, mq_pop, mq_empty, mq_full;
  logic [MSG_W-1:0] mq_rdata;

  assign req_ready = !mq_full;
  assign mq_push   = req_valid && req_ready;

  nif_fifo #(.W(MSG_W), .DEPTH(MSGQ_DEPTH)) u_msgq (
    .clk(clk), .rst_n(rst_s),
    .push(mq_push), .wdata({dest_node, padded}),
    .pop(mq_pop), .rdata(mq_rdata),
    .empty(mq_empty), .full(mq_full)
  );

  logic              ob_push, ob_pop, ob_empty, ob_full;
  logic [FLIT_W-1:0] ob_wdata;

  nif_tx_packer u_pack (
    .clk(clk), .rst_n(rst_s),
    .msg_valid(!mq_empty),
    .msg_node(mq_rdata[MSG_W-1 -: NODE_W]),
    .msg_payload(mq_rdata[PAYLOAD_W-1:0]),
    .msg_pop(mq_pop),
    .flit_full(ob_full),
    .flit_push(ob_push),
    .flit_data(ob_wdata)
  );

  assign out_valid = !ob_empty;
  assign ob_pop    = out_valid && out_ready;

  nif_fifo #(.W(FLIT_W), .DEPTH(FLITBUF_DEPTH)) u_outbuf (
    .clk(clk), .rst_n(rst_s),
    .push(ob_push), .wdata(ob_wdata),
    .pop(ob_pop), .rdata(out_flit),
    .empty(ob_empty), .full(ob_full)
  );

  logic              ib_push, ib_pop, ib_empty, ib_full;
  logic [FLIT_W-1:0] ib_rdata;

  assign in_ready = !ib_full;
  assign ib_push  = in_valid && in_ready;

  nif_fifo #(.W(FLIT_W), .DEPTH(FLITBUF_DEPTH)) u_inbuf (
    .clk(clk), .rst_n(rst_s),
    .push(ib_push), .wdata(in_flit),
    .pop(ib_pop), .rdata(ib_rdata),
    .empty(ib_empty), .full(ib_full)
  );

  nif_rx_assembler u_asm (
    .clk(clk), .rst_n(rst_s),
    .flit_avail(!ib_empty), .flit_data(ib_rdata), .flit_pop(ib_pop),
    .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_src(rx_src), .rx_payload(rx_payload)
  );

  // R4: a stalled outgoing flit stays put
  a_r4_out_hold: assert property (@(posedge clk) disable iff (!rst_s)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_flit)));
  // R6: the queue never refuses while empty of messages
  a_r6_ready_when_empty: assert property (@(posedge clk) disable iff (!rst_s)
    (mq_empty |-> req_ready));
endmodule

// File: tb/nif_top_test.sv
module nif_top_test;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         req_valid, req_ready;
  logic [5:0]   req_core_id, req_nbytes;
  logic [447:0] req_payload;
  logic         out_valid, out_ready;
  logic [63:0]  out_flit;
  logic         in_valid, in_ready;
  logic [63:0]  in_flit;
  logic         rx_valid, rx_ready;
  logic [5:0]   rx_src;
  logic [447:0] rx_payload;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nif_top uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_core_id(req_core_id),
    .req_nbytes(req_nbytes), .req_payload(req_payload),
    .out_valid(out_valid), .out_ready(out_ready), .out_flit(out_flit),
    .in_valid(in_valid), .in_ready(in_ready), .in_flit(in_flit),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_src(rx_src), .rx_payload(rx_payload)
  );

  logic [63:0] txlog [0:127];
  int txn = 0;
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready && txn < 128) begin
      txlog[txn] = out_flit;
      txn++;
    end
  end

  task automatic check(input string req, input logic [447:0] act, input logic [447:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [447:0] raw_payload(input int seed);
    logic [447:0] p;
    for (int j = 0; j < 56; j++) p[8*j +: 8] = 8'((seed + 3*j + 1) & 255);
    return p;
  endfunction

  function automatic logic [447:0] pad_payload(input int seed, input int nb);
    logic [447:0] p;
    p = raw_payload(seed);
    for (int j = 0; j < 56; j++) if (j >= nb) p[8*j +: 8] = 8'h00;
    return p;
  endfunction

  function automatic logic [63:0] exp_flit(input logic [5:0] node, input logic [447:0] p, input int k);
    logic [63:0] f;
    f[63]    = (k == 0);
    f[62]    = (k == 7);
    f[61:56] = (k == 0) ? node : 6'(k);
    f[55:0]  = p[56*k +: 56];
    return f;
  endfunction

  task automatic send_msg(input int core, input int nb, input int seed);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid   = 1'b1;
    req_core_id = 6'(core);
    req_nbytes  = 6'(nb);
    req_payload = raw_payload(seed);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic check_msg(input string req, input int base, input int core, input int nb, input int seed);
    logic [447:0] p;
    p = pad_payload(seed, nb);
    for (int k = 0; k < 8; k++)
      check(req, 448'(txlog[base+k]), 448'(exp_flit(6'((core + 5) % 64), p, k)));
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    req_valid = 0; req_core_id = 0; req_nbytes = 0; req_payload = '0;
    out_ready = 1; in_valid = 0; in_flit = '0; rx_ready = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 idle outputs after reset
    check("R1 req_ready", 448'(req_ready), 448'(1));
    check("R1 in_ready",  448'(in_ready),  448'(1));
    check("R1 out_valid", 448'(out_valid), 448'(0));
    check("R1 rx_valid",  448'(rx_valid),  448'(0));
  endtask

  task automatic t_basic;
    int base;
    base = txn;
    send_msg(3, 56, 7);
    // R8 head not yet visible one edge after acceptance
    check("R8 out_valid early", 448'(out_valid), 448'(0));
    @(negedge clk);
    check("R8 out_valid on time", 448'(out_valid), 448'(1));
    repeat (12) @(negedge clk);
    check("R4 flit count", 448'(txn - base), 448'(8));
    // R2 R3 R4 flit contents
    check_msg("R2 R3 R4 flit", base, 3, 56, 7);
  endtask

  task automatic t_pad_and_wrap;
    int base;
    base = txn;
    send_msg(20, 10, 33);
    send_msg(62, 60, 90);
    repeat (25) @(negedge clk);
    check("R5 flit count", 448'(txn - base), 448'(16));
    check_msg("R5 zero pad", base, 20, 10, 33);
    // R3 wrap: node (62+5) mod 64 = 3; R5 count above 56 keeps all bytes
    check_msg("R3 R5 wrap clamp", base + 8, 62, 56, 90);
  endtask

  task automatic t_stall_order;
    int acc, base;
    logic [63:0] held;
    base = txn;
    acc  = 0;
    @(negedge clk);
    out_ready = 1'b0;
    for (int i = 0; i < 40; i++) begin
      bit hs;
      req_valid   = 1'b1;
      req_core_id = 6'(acc);
      req_nbytes  = 6'd56;
      req_payload = raw_payload(100 + acc);
      hs = req_ready;
      @(negedge clk);
      if (hs) acc++;
    end
    req_valid = 1'b0;
    // R6 four queued plus one buffered
    check("R6 accepted while stalled", 448'(acc), 448'(5));
    check("R6 ready low when full", 448'(req_ready), 448'(0));
    held = out_flit;
    @(negedge clk);
    check("R4 stalled flit stable", 448'(out_flit), 448'(held));
    check("R4 stalled valid", 448'(out_valid), 448'(1));
    out_ready = 1'b1;
    repeat (60) @(negedge clk);
    check("R7 flits drained", 448'(txn - base), 448'(40));
    // R7 acceptance order
    for (int m = 0; m < 5; m++) check_msg("R7 order", base + 8*m, m, 56, 100 + m);
  endtask

  task automatic push_flits(input logic [63:0] f [], input int ncyc, output int acc);
    acc = 0;
    for (int i = 0; i < ncyc; i++) begin
      bit hs;
      if (acc < f.size()) begin
        in_valid = 1'b1;
        in_flit  = f[acc];
      end else in_valid = 1'b0;
      hs = in_valid && in_ready;
      @(negedge clk);
      if (hs) acc++;
    end
    in_valid = 1'b0;
  endtask

  task automatic t_rx_basic;
    logic [63:0] f [];
    logic [447:0] p;
    int acc;
    p = raw_payload(61);
    f = new[7];
    for (int k = 0; k < 7; k++) f[k] = exp_flit(6'd44, p, k);
    rx_ready = 1'b0;
    push_flits(f, 12, acc);
    repeat (4) @(negedge clk);
    // R9 nothing offered before the tail
    check("R9 no early delivery", 448'(rx_valid), 448'(0));
    f = new[1];
    f[0] = exp_flit(6'd44, p, 7);
    push_flits(f, 2, acc);
    repeat (3) @(negedge clk);
    check("R9 delivered after tail", 448'(rx_valid), 448'(1));
    check("R9 source node", 448'(rx_src), 448'(44));
    check("R9 payload", rx_payload, p);
    repeat (3) @(negedge clk);
    // R10 held while core stalls
    check("R10 still valid", 448'(rx_valid), 448'(1));
    check("R10 payload held", rx_payload, p);
    rx_ready = 1'b1;
    @(negedge clk);
    rx_ready = 1'b0;
    check("R10 taken", 448'(rx_valid), 448'(0));
  endtask

  task automatic t_rx_stall;
    logic [63:0] f [];
    int acc, got;
    f = new[24];
    for (int m = 0; m < 3; m++)
      for (int k = 0; k < 8; k++) f[8*m+k] = exp_flit(6'(10 + m), raw_payload(50 + m), k);
    rx_ready = 1'b0;
    push_flits(f, 40, acc);
    // R10 one message assembled plus eight buffered
    check("R10 flits taken while stalled", 448'(acc), 448'(16));
    check("R10 in_ready low", 448'(in_ready), 448'(0));
    rx_ready = 1'b1;
    got = 0;
    for (int i = 0; i < 40; i++) begin
      if (rx_valid) begin
        if (got < 2) begin
          check("R9 stalled src", 448'(rx_src), 448'(10 + got));
          check("R9 stalled payload", rx_payload, raw_payload(50 + got));
        end
        got++;
      end
      @(negedge clk);
    end
    rx_ready = 1'b0;
    check("R10 messages delivered", 448'(got), 448'(2));
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    t_reset();
    t_basic();
    t_pad_and_wrap();
    t_stall_order();
    t_rx_basic();
    t_rx_stall();
    finish_run();
  end
endmodule